// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between the interrupt distributor and a single processor. The distributor offers one candidate interrupt at a time: an ID, an 8-bit priority and, for software-raised interrupts, the number of the CPU that raised it. The block compares that candidate against a software-set priority mask and against the priority of the interrupt already being serviced. When the candidate wins both comparisons and signalling is enabled, it raises the request line to the processor.

Software takes an interrupt by reading the acknowledge register. A qualifying read returns the ID, consumes the candidate through a valid/ready handshake, and records the interrupt as active. An empty read returns the spurious code 1023. Software retires an interrupt by writing its ID to the end-of-interrupt register.

Up to `ACT_DEPTH` interrupts can be active at once. The default of 2 allows one level of pre-emption. The most recently taken interrupt sets the running priority.

The candidate port follows valid/ready rules with one relaxation. The offer is a proposal, not a committed beat: the distributor may withdraw it or replace it in any cycle. A transfer happens only in a cycle where `fwd_valid_i` and `fwd_ready_o` are both high. `fwd_ready_o` is high only during a qualifying acknowledge read. In that same cycle the distributor must clear the pending state of the transferred source. The register port takes one access per cycle. A cycle that has both read and write strobes high performs the write and ignores the read.

Top module: `irq_cpu_port`

## Requirements
- R1: `irq_o` is high exactly when all of these hold in the same cycle: signalling is enabled, `fwd_valid_i` is high, `fwd_prio_i` is strictly below the priority mask, `fwd_prio_i` is strictly below the running priority, and fewer than `ACT_DEPTH` interrupts are active. When nothing is active, the running priority is 0xFF.
- R2: The control register is at address 0 and bit 0 enables signalling. While that bit is 0, `irq_o` stays low and every acknowledge read returns the spurious code.
- R3: The priority mask register is at address 1 and is 8 bits wide. It resets to 0xF0 and reads back the value written. A candidate whose priority equals the mask is not signalled.
- R4: The acknowledge register is at address 2. Reading it while `irq_o` is high drives `fwd_ready_o` high in that cycle and returns the candidate ID in bits [9:0].
- R5: Reading the acknowledge register while `irq_o` is low returns 1023. It leaves `fwd_ready_o` low and changes no state.
- R6: If the acknowledged ID is below 16, bits [12:10] of the returned word carry `fwd_src_i`. For any other ID those bits are 0.
- R7: A taken interrupt's priority becomes the running priority. Candidates of equal or numerically higher value are then not signalled until that interrupt is retired.
- R8: A candidate with a numerically lower priority than the running one can be taken while another interrupt is active. Once `ACT_DEPTH` interrupts are active, nothing is signalled.
- R9: The end-of-interrupt register is at address 3. Writing it with the ID of the most recently taken active interrupt retires that interrupt, and the running priority reverts to the previous active interrupt's priority, or to 0xFF.
- R10: An end-of-interrupt write whose ID does not match the most recently taken active interrupt has no effect.
- R11: A read returns its data with `rd_valid_o` high exactly one cycle after the read strobe. Reading address 0 returns the enable in bit 0. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_valid_i | input | 1 | Distributor offers a candidate |
| fwd_ready_o | output | 1 | Candidate taken this cycle by an acknowledge read |
| fwd_id_i | input | 10 | Candidate interrupt ID |
| fwd_prio_i | input | 8 | Candidate priority, lower value is more urgent |
| fwd_src_i | input | 3 | Requesting CPU for software IDs |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 10 | Register write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 13 | Read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench targets the boundaries of the priority comparisons:
- A candidate whose priority exactly equals the mask must not be signalled. A design that used "less than or equal" would raise `irq_o` there.
- A candidate whose priority equals the running priority must also stay silent. A design that got this wrong would pre-empt itself.

The bench also checks acknowledge reads with nothing qualifying. A design that changed state on such a read would add a phantom active entry, and that entry would then block later requests.

An end-of-interrupt write that names the older of two active interrupts must leave the state alone. A design that retired by ID anywhere in the stack, or that retired blindly, would restore the wrong running priority and signal too early.

Finally, the bench checks the source field of the returned word for IDs on both sides of 16. A design that got this wrong would leak the CPU number into peripheral IDs.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PMASK = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_EOI   = 2'd3
  } reg_sel_e;

  localparam int unsigned SPURIOUS_ID = 1023;
  localparam int unsigned SOFT_ID_LIMIT = 16;
endpackage

// File: rtl/irq_cpu_ctrl_regs.sv
module irq_cpu_ctrl_regs #(
  parameter int PW = 8,
  parameter logic [PW-1:0] PMASK_RST = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic          wr_pmask_i,
  input  logic [PW-1:0] wdata_i,
  output logic          en_o,
  output logic [PW-1:0] pmask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      pmask_o <= PMASK_RST;
    end else begin
      if (wr_ctrl_i)  en_o    <= wdata_i[0];
      if (wr_pmask_i) pmask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_cpu_active_stack.sv
module irq_cpu_active_stack #(
  parameter int DEPTH = 2,
  parameter int IDW   = 10,
  parameter int PW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic [IDW-1:0] push_id_i,
  input  logic [PW-1:0]  push_prio_i,
  input  logic           pop_req_i,
  input  logic [IDW-1:0] pop_id_i,
  output logic [PW-1:0]  run_prio_o,
  output logic           full_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]  cnt_q;
  logic [IDW-1:0] id_q [DEPTH];
  logic [PW-1:0]  pr_q [DEPTH];
  logic [IDW-1:0] top_id;
  logic [PW-1:0]  top_pr;
  logic           push_ok, pop_ok;

  always_comb begin
    top_id = '0;
    top_pr = '1;
    for (int k = 0; k < DEPTH; k++) begin
      if (cnt_q == CW'(k + 1)) begin
        top_id = id_q[k];
        top_pr = pr_q[k];
      end
    end
  end

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign push_ok    = push_i && !full_o;
  assign pop_ok     = pop_req_i && (cnt_q != '0) && (pop_id_i == top_id);
  assign run_prio_o = top_pr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (push_ok) cnt_q <= cnt_q + 1'b1;
    else if (pop_ok)  cnt_q <= cnt_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[g] <= '0;
        pr_q[g] <= '0;
      end else if (push_ok && cnt_q == CW'(g)) begin
        id_q[g] <= push_id_i;
        pr_q[g] <= push_prio_i;
      end
    end
  end

  // R8
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/irq_cpu_qualify.sv
module irq_cpu_qualify #(
  parameter int PW = 8
) (
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [PW-1:0] prio_i,
  input  logic [PW-1:0] pmask_i,
  input  logic [PW-1:0] run_prio_i,
  input  logic          full_i,
  output logic          req_o
);
  assign req_o = en_i && valid_i && !full_i &&
                 (prio_i < pmask_i) && (prio_i < run_prio_i);
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int IDW       = 10,
  parameter int PW        = 8,
  parameter int CPUW      = 3,
  parameter int ACT_DEPTH = 2,
  parameter int RDW       = IDW + CPUW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fwd_valid_i,
  output logic            fwd_ready_o,
  input  logic [IDW-1:0]  fwd_id_i,
  input  logic [PW-1:0]   fwd_prio_i,
  input  logic [CPUW-1:0] fwd_src_i,
  input  logic            reg_rd_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [IDW-1:0]  reg_wdata_i,
  output logic            rd_valid_o,
  output logic [RDW-1:0]  rd_data_o,
  output logic            irq_o
);
  import irq_cpu_pkg::*;

  reg_sel_e       sel;
  logic           rd_acc, ack_rd, eoi_wr;
  logic           en, full, req;
  logic [PW-1:0]  pmask, run_prio;
  logic [RDW-1:0] ack_word;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign rd_acc = reg_rd_i && !reg_wr_i;
  assign ack_rd = rd_acc && (sel == SEL_ACK);
  assign eoi_wr = reg_wr_i && (sel == SEL_EOI);

  irq_cpu_ctrl_regs #(.PW(PW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl_i  (reg_wr_i && sel == SEL_CTRL),
    .wr_pmask_i (reg_wr_i && sel == SEL_PMASK),
    .wdata_i    (reg_wdata_i[PW-1:0]),
    .en_o       (en),
    .pmask_o    (pmask)
  );

  irq_cpu_qualify #(.PW(PW)) u_qual (
    .en_i       (en),
    .valid_i    (fwd_valid_i),
    .prio_i     (fwd_prio_i),
    .pmask_i    (pmask),
    .run_prio_i (run_prio),
    .full_i     (full),
    .req_o      (req)
  );

  irq_cpu_active_stack #(.DEPTH(ACT_DEPTH), .IDW(IDW), .PW(PW)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ack_rd && req),
    .push_id_i   (fwd_id_i),
    .push_prio_i (fwd_prio_i),
    .pop_req_i   (eoi_wr),
    .pop_id_i    (reg_wdata_i),
    .run_prio_o  (run_prio),
    .full_o      (full)
  );

  assign irq_o       = req;
  assign fwd_ready_o = ack_rd && req;
  assign ack_word    = {(fwd_id_i < IDW'(SOFT_ID_LIMIT)) ? fwd_src_i : CPUW'(0), fwd_id_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_acc;
      if (rd_acc) begin
        unique case (sel)
          SEL_CTRL:  rd_data_o <= RDW'(en);
          SEL_PMASK: rd_data_o <= RDW'(pmask);
          SEL_ACK:   rd_data_o <= req ? ack_word : RDW'(SPURIOUS_ID);
          default:   rd_data_o <= '0;
        endcase
      end
    end
  end

  // R4
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready_o |-> fwd_valid_i);
  // R4
  ack_returns_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready_o |=> (rd_data_o[IDW-1:0] == $past(fwd_id_i)));
  // R2
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o);
  // R7
  run_prio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready_o |=> (run_prio == $past(fwd_prio_i)));
  // R5
  spurious_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !req) |=> ($stable(run_prio) && $stable(full)));
  // R11
  rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_acc));
endmodule

// File: tb/tb_irq_cpu_port.sv
`timescale 1ns/1ps
module tb_irq_cpu_port;
  localparam int DEPTH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_valid_i = 1'b0;
  logic        fwd_ready_o;
  logic [9:0]  fwd_id_i = '0;
  logic [7:0]  fwd_prio_i = '0;
  logic [2:0]  fwd_src_i = '0;
  logic        reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [9:0]  reg_wdata_i = '0;
  logic        rd_valid_o;
  logic [12:0] rd_data_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit m_en = 0;
  int m_pmask = 'hF0;
  int q_id[$];
  int q_pr[$];

  always #10 clk = ~clk;

  irq_cpu_port dut (
    .clk(clk), .rst_n(rst_n),
    .fwd_valid_i(fwd_valid_i), .fwd_ready_o(fwd_ready_o),
    .fwd_id_i(fwd_id_i), .fwd_prio_i(fwd_prio_i), .fwd_src_i(fwd_src_i),
    .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_run();
    return (q_pr.size() > 0) ? q_pr[q_pr.size()-1] : 256;
  endfunction

  function automatic bit m_qual();
    return m_en && fwd_valid_i && (int'(fwd_prio_i) < m_pmask) &&
           (int'(fwd_prio_i) < m_run()) && (q_id.size() < DEPTH);
  endfunction

  task automatic offer(input bit v, input int id, input int pr, input int src);
    fwd_valid_i = v;
    fwd_id_i    = 10'(id);
    fwd_prio_i  = 8'(pr);
    fwd_src_i   = 3'(src);
  endtask

  // one bus cycle; called at a negedge, returns at the next negedge
  task automatic step(input bit rd, input bit wr, input int addr, input int wd, input string req);
    bit eq;
    bit er;
    int ed;
    reg_rd_i = rd; reg_wr_i = wr; reg_addr_i = 2'(addr); reg_wdata_i = 10'(wd);
    #1;
    eq = m_qual();
    chk(irq_o == eq, "R1 irq", int'(irq_o), int'(eq));
    er = rd && addr == 2 && eq;
    chk(fwd_ready_o == er, "R4 ready", int'(fwd_ready_o), int'(er));
    ed = 0;
    if (rd) begin
      case (addr)
        0: ed = int'(m_en);
        1: ed = m_pmask;
        2: begin
          if (eq) begin
            ed = ((fwd_id_i < 16) ? (int'(fwd_src_i) << 10) : 0) | int'(fwd_id_i);
            q_id.push_back(int'(fwd_id_i));
            q_pr.push_back(int'(fwd_prio_i));
          end else ed = 1023;
        end
        default: ed = 0;
      endcase
    end
    if (wr) begin
      case (addr)
        0: m_en = wd[0];
        1: m_pmask = wd & 'hFF;
        3: if (q_id.size() > 0 && q_id[q_id.size()-1] == (wd & 'h3FF)) begin
             void'(q_id.pop_back());
             void'(q_pr.pop_back());
           end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    reg_rd_i = 0; reg_wr_i = 0;
    @(negedge clk);
    chk(rd_valid_o == rd, "R11 rd_valid", int'(rd_valid_o), int'(rd));
    if (rd) chk(int'(rd_data_o) == ed, req, int'(rd_data_o), ed);
  endtask

  task automatic expect_irq(input bit e, input string req);
    #1;
    chk(irq_o == e, req, int'(irq_o), int'(e));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(irq_o == 0, "R1 reset irq", int'(irq_o), 0);
    chk(rd_valid_o == 0, "R11 reset rd_valid", int'(rd_valid_o), 0);
    step(1, 0, 1, 0, "R3 pmask reset 0xF0");
    step(1, 0, 0, 0, "R11 ctrl reads 0");
    step(1, 0, 3, 0, "R11 eoi reads 0");

    // disabled: no signal, spurious ack
    offer(1, 40, 'h80, 0);
    expect_irq(0, "R2 disabled");
    step(1, 0, 2, 0, "R2 R5 spurious while disabled");
    step(0, 1, 0, 1, "R2 enable");
    expect_irq(1, "R1 enabled");
    step(1, 0, 0, 0, "R11 ctrl reads 1");

    // mask boundary
    step(0, 1, 1, 'h80, "R3 mask write");
    expect_irq(0, "R3 equal to mask blocked");
    step(1, 0, 1, 0, "R3 mask readback");
    step(0, 1, 1, 'h81, "R3 mask write");
    expect_irq(1, "R3 below mask");

    // take 40
    step(1, 0, 2, 0, "R4 ack id 40");
    offer(1, 50, 'h80, 2);
    expect_irq(0, "R7 equal running priority blocked");
    step(1, 0, 2, 0, "R5 spurious while blocked");
    expect_irq(0, "R5 no state change");

    // pre-empt with software id 3 from cpu 5
    offer(1, 3, 'h40, 5);
    expect_irq(1, "R8 preempt");
    step(1, 0, 2, 0, "R6 soft id carries source");
    offer(1, 60, 'h10, 5);
    expect_irq(0, "R8 full blocks");

    // mismatched EOI ignored, matching retires
    step(0, 1, 3, 40, "R10 eoi older id");
    expect_irq(0, "R10 ignored");
    step(0, 1, 3, 3, "R9 eoi top");
    expect_irq(1, "R9 running restored");
    step(0, 1, 3, 40, "R9 eoi last");
    step(1, 0, 2, 0, "R6 peripheral id has no source");
    step(0, 1, 3, 60, "R9 retire 60");
    offer(1, 70, 'h20, 1);
    expect_irq(1, "R1 pending again");
    step(0, 1, 0, 0, "R2 disable");
    expect_irq(0, "R2 disabled gate");
    step(1, 0, 2, 0, "R2 spurious after disable");
    step(0, 1, 0, 1, "R2 re-enable");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int op;
      int wd;
      offer($urandom_range(0, 3) != 0, $urandom_range(0, 40), $urandom_range(0, 255),
            $urandom_range(0, 7));
      op = $urandom_range(0, 9);
      wd = $urandom_range(0, 1023);
      if (op == 9 && q_id.size() > 0 && $urandom_range(0, 1) == 1)
        wd = q_id[q_id.size()-1];
      case (op)
        0, 1, 2, 3: step(1, 0, 2, 0, "R4 R6 random ack");
        4:          step(1, 0, $urandom_range(0, 3), 0, "R11 random read");
        5:          step(0, 1, 1, $urandom_range(96, 255), "R3 random mask");
        6:          step(0, 1, 0, ($urandom_range(0, 7) != 0) ? 1 : 0, "R2 random ctrl");
        7:          step(0, 0, 0, 0, "R1 idle");
        default:    step(0, 1, 3, wd, "R9 R10 random eoi");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule